// File: doc/BRIEF.md
# Crossbar Transmit Frame Packer

The packer turns a packet, offered one byte per cycle, into the sequence of 128-bit words that a wormhole-routed crossbar expects on its transmit FIFO. Each frame opens with a routing word for the chosen output channel; the switch consumes that word and forwards the rest. An in-band length field of eight bytes follows. The payload comes after it, packed densely into 16-byte words. The frame ends on a word flagged as last.

The payload length and the destination channel arrive with the first byte. Bytes that do not yet fill a word stay in a remainder register until later bytes complete it, or until the packet ends and the remainder is padded out. The transmit FIFO is not observed directly. The block keeps a credit count of the free entries, stalls when the count reaches zero, and refills it only when the FIFO reports that it has drained completely.

Top module: `xbar_frame_packer`

## Requirements
- R1: After reset, out_valid, out_last and err are low, in_ready is low, and the remainder register is empty.
- R2: The first word of an accepted frame is the routing word, with out_last low. For channel index i = in_chan - 1 (4 bits), the routing word holds {^i, i} in each of the 25 five-bit groups at bits [5g+4:5g], g = 0..24, and zeros in bits 127:125.
- R3: Channels 1 to 12 are accepted. Any other value on the first byte raises err for exactly one cycle. The block writes no word for that packet and still consumes all of its bytes, up to and including the one with in_last.
- R4: The second word starts with the length field: bits 63:0 carry in_len + 8 as an unsigned little-endian value.
- R5: Stream bytes (length field, then payload) are packed contiguously and little-endian. Stream byte k of the body lands in bits [8(k mod 16)+7 : 8(k mod 16)] of body word k/16.
- R6: If the last payload byte leaves 1 to 15 bytes in the remainder, those bytes go out zero-padded in the final word, with out_last high.
- R7: If the body ends exactly on a word boundary, the block writes one extra all-zero word with out_last high.
- R8: Starting from reset, the block writes at most DEPTH (60) words. It then writes nothing until fifo_empty is seen high, after which it may write DEPTH more.
- R9: in_chan and in_len are sampled only with the first byte. Changes to them later in the packet have no effect on the frame.
- R10: out_last is high on exactly one word per frame, the final one, and never without out_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Payload byte valid |
| in_data | input | 8 | Payload byte |
| in_last | input | 1 | Marks the final payload byte |
| in_chan | input | 4 | Destination channel, sampled with the first byte |
| in_len | input | 14 | Payload byte count, sampled with the first byte |
| in_ready | output | 1 | Byte accepted when high together with in_valid |
| fifo_empty | input | 1 | Transmit FIFO has fully drained |
| out_valid | output | 1 | Write strobe to the transmit FIFO |
| out_data | output | 128 | Word written to the FIFO |
| out_last | output | 1 | Last-word flag for the written word |
| err | output | 1 | One-cycle pulse when a packet is rejected |

## Verification
The bench aims at the payload sizes that bring the body exactly to a word boundary (8, 24, 40 bytes). A packer that got this wrong would drop the all-zero close word, or flag a data word as last. Single-byte payloads and random lengths test whether the remainder is carried across words: a wrong carry shows up as shifted or missing bytes. Long random traffic drives the credit count to zero, and a broken credit count writes a 61st word or never resumes. Out-of-range channels and mid-packet changes to in_chan and in_len check that rejected packets are swallowed whole and that the header values are sampled only once.

// File: rtl/xbp_pkg.sv
package xbp_pkg;
  localparam int WORD_W  = 128;
  localparam int WORD_B  = WORD_W / 8;
  localparam int LENF_B  = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ROUTE,
    ST_BODY,
    ST_CLOSE,
    ST_DROP
  } xbp_state_e;
endpackage

// File: rtl/xbp_route.sv
module xbp_route #(
  parameter int CH_W   = 4,
  parameter int WORD_W = 128
) (
  input  logic [CH_W-1:0]   idx,
  output logic [WORD_W-1:0] code
);
  localparam int GW  = CH_W + 1;
  localparam int NG  = WORD_W / GW;
  localparam int REM = WORD_W - NG * GW;

  logic [GW-1:0] group;
  assign group = {^idx, idx};

  genvar g;
  generate
    for (g = 0; g < NG; g++) begin : g_grp
      assign code[g*GW +: GW] = group;
    end
    if (REM > 0) begin : g_rem
      assign code[WORD_W-1 -: REM] = '0;
    end
  endgenerate
endmodule

// File: rtl/xbp_credit.sv
module xbp_credit #(
  parameter int DEPTH = 60
) (
  input  logic clk,
  input  logic rst,
  input  logic wr,
  input  logic drained,
  output logic can_wr
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [CW-1:0] free_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      free_q <= CW'(DEPTH);
    end else if (wr) begin
      free_q <= free_q - 1'b1;
    end else if (free_q == '0 && drained) begin
      free_q <= CW'(DEPTH);
    end
  end

  assign can_wr = (free_q != '0);

  // R8: a write never consumes a credit that is not there
  a_r8_no_overflow: assert property (@(posedge clk) disable iff (rst)
    wr |-> free_q != '0);
  // R8: the credit count stays within the FIFO depth
  a_r8_credit_bounded: assert property (@(posedge clk) disable iff (rst)
    free_q <= CW'(DEPTH));
endmodule

// File: rtl/xbp_accum.sv
module xbp_accum #(
  parameter int WORD_B = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  load,
  input  logic [63:0]           load_val,
  input  logic                  clr,
  input  logic                  push,
  input  logic [7:0]            push_byte,
  output logic [WORD_B*8-1:0]   word,
  output logic [$clog2(WORD_B+1)-1:0] cnt
);
  localparam int CNT_W = $clog2(WORD_B + 1);
  localparam int PRE_B = 8;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= CNT_W'(PRE_B);
    end else if (clr) begin
      cnt_q <= '0;
    end else if (push) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  genvar k;
  generate
    for (k = 0; k < WORD_B; k++) begin : g_lane
      logic [7:0] lane_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          lane_q <= '0;
        end else if (load) begin
          if (k < PRE_B) lane_q <= load_val[(k % PRE_B)*8 +: 8];
          else           lane_q <= '0;
        end else if (clr) begin
          lane_q <= '0;
        end else if (push && cnt_q == CNT_W'(k)) begin
          lane_q <= push_byte;
        end
      end
      assign word[k*8 +: 8] = lane_q;
    end
  endgenerate

  assign cnt = cnt_q;

  // R5: the remainder never holds more than one word
  a_r5_cnt_bounded: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_W'(WORD_B));
  // R5: no byte is pushed into a full word
  a_r5_no_push_full: assert property (@(posedge clk) disable iff (rst)
    push |-> cnt_q < CNT_W'(WORD_B));
endmodule

// File: rtl/xbar_frame_packer.sv
module xbar_frame_packer
  import xbp_pkg::*;
#(
  parameter int DEPTH    = 60,
  parameter int LEN_W    = 14,
  parameter int CH_W     = 4,
  parameter int CHANNELS = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  input  logic              in_last,
  input  logic [CH_W-1:0]   in_chan,
  input  logic [LEN_W-1:0]  in_len,
  output logic              in_ready,
  input  logic              fifo_empty,
  output logic              out_valid,
  output logic [127:0]      out_data,
  output logic              out_last,
  output logic              err
);
  localparam int CNT_W = $clog2(WORD_B + 1);

  xbp_state_e         state_q, state_d;
  logic [CH_W-1:0]    idx_q;
  logic [LEN_W-1:0]   len_q;
  logic               chan_ok;
  logic               can_wr;
  logic               emit, emit_last;
  logic [WORD_W-1:0]  emit_word;
  logic               acc_load, acc_clr, acc_push;
  logic [WORD_W-1:0]  acc_word;
  logic [CNT_W-1:0]   acc_cnt;
  logic [WORD_W-1:0]  route_word;
  logic               err_set;
  logic [63:0]        len_field;

  assign chan_ok   = (in_chan >= CH_W'(1)) && (in_chan <= CH_W'(CHANNELS));
  assign len_field = 64'(len_q) + 64'(LENF_B);

  xbp_route #(.CH_W(CH_W), .WORD_W(WORD_W)) u_route (
    .idx  (idx_q),
    .code (route_word)
  );

  xbp_credit #(.DEPTH(DEPTH)) u_credit (
    .clk     (clk),
    .rst     (rst),
    .wr      (emit),
    .drained (fifo_empty),
    .can_wr  (can_wr)
  );

  xbp_accum #(.WORD_B(WORD_B)) u_accum (
    .clk       (clk),
    .rst       (rst),
    .load      (acc_load),
    .load_val  (len_field),
    .clr       (acc_clr),
    .push      (acc_push),
    .push_byte (in_data),
    .word      (acc_word),
    .cnt       (acc_cnt)
  );

  always_comb begin
    state_d   = state_q;
    in_ready  = 1'b0;
    emit      = 1'b0;
    emit_last = 1'b0;
    emit_word = acc_word;
    acc_load  = 1'b0;
    acc_clr   = 1'b0;
    acc_push  = 1'b0;
    err_set   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (in_valid) begin
          if (chan_ok) begin
            state_d = ST_ROUTE;
          end else begin
            state_d = ST_DROP;
            err_set = 1'b1;
          end
        end
      end
      ST_ROUTE: begin
        if (can_wr) begin
          emit      = 1'b1;
          emit_word = route_word;
          acc_load  = 1'b1;
          state_d   = ST_BODY;
        end
      end
      ST_BODY: begin
        if (acc_cnt == CNT_W'(WORD_B)) begin
          if (can_wr) begin
            emit    = 1'b1;
            acc_clr = 1'b1;
          end
        end else begin
          in_ready = 1'b1;
          if (in_valid) begin
            acc_push = 1'b1;
            if (in_last) state_d = ST_CLOSE;
          end
        end
      end
      ST_CLOSE: begin
        if (can_wr) begin
          emit    = 1'b1;
          acc_clr = 1'b1;
          if (acc_cnt != CNT_W'(WORD_B)) begin
            emit_last = 1'b1;
            state_d   = ST_IDLE;
          end
        end
      end
      ST_DROP: begin
        in_ready = 1'b1;
        if (in_valid && in_last) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      idx_q     <= '0;
      len_q     <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_last  <= 1'b0;
      err       <= 1'b0;
    end else begin
      state_q   <= state_d;
      out_valid <= emit;
      out_last  <= emit_last;
      err       <= err_set;
      if (emit) out_data <= emit_word;
      if (state_q == ST_IDLE && in_valid) begin
        idx_q <= in_chan - CH_W'(1);
        len_q <= in_len;
      end
    end
  end

  // R10: the last flag only travels with a written word
  a_r10_last_needs_valid: assert property (@(posedge clk) disable iff (rst)
    out_last |-> out_valid);
  // R3: a rejection is reported as a single-cycle pulse
  a_r3_err_single: assert property (@(posedge clk) disable iff (rst)
    err |=> !err);
  // R3: a rejected packet never reaches the FIFO
  a_r3_drop_silent: assert property (@(posedge clk) disable iff (rst)
    state_q == ST_DROP |-> !emit);
  // R2: the word after a frame start is the routing word, never a last word
  a_r2_route_not_last: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_ROUTE && emit) |=> (out_valid && !out_last));
  // R9: header registers hold while a frame is in flight
  a_r9_header_stable: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_BODY && $past(state_q) == ST_BODY) |-> ($stable(idx_q) && $stable(len_q)));
endmodule

// File: tb/xbar_frame_packer_test.sv
module xbar_frame_packer_test;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [7:0]   in_data = '0;
  logic         in_last = 1'b0;
  logic [3:0]   in_chan = '0;
  logic [13:0]  in_len = '0;
  logic         in_ready;
  logic         fifo_empty = 1'b0;
  logic         out_valid;
  logic [127:0] out_data;
  logic         out_last;
  logic         err;

  int checks = 0;
  int errors = 0;
  int since_empty = 0;
  int err_seen = 0;
  logic [127:0] got_w[$];
  bit           got_l[$];
  logic [7:0]   pay[0:255];
  logic [7:0]   stream[0:511];

  always #5 clk = ~clk;

  xbar_frame_packer uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .in_last(in_last), .in_chan(in_chan), .in_len(in_len),
    .in_ready(in_ready), .fifo_empty(fifo_empty), .out_valid(out_valid),
    .out_data(out_data), .out_last(out_last), .err(err)
  );

  function automatic logic [127:0] exp_route(int addr);
    logic [3:0]   i;
    logic [127:0] r;
    i = 4'(addr - 1);
    r = '0;
    for (int g = 0; g < 25; g++) r[g*5 +: 5] = {^i, i};
    return r;
  endfunction

  task automatic check(bit ok, string req, string what, logic [127:0] act, logic [127:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
    end
  endtask

  // Output monitor
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && out_valid) begin
        got_w.push_back(out_data);
        got_l.push_back(out_last);
      end
      if (!rst && err) err_seen++;
    end
  end

  // FIFO drain model: counts writes and reports empty after a delay
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && out_valid) since_empty++;
      if (since_empty > 60)
        check(0, "R8", "words written without drain", 128'(since_empty), 128'd60);
      if (since_empty == 60) begin
        for (int w = 0; w < 8; w++) begin
          @(negedge clk);
          if (out_valid) begin
            if (err_seen >= 0) since_empty++;
            check(0, "R8", "write while FIFO full", 128'(since_empty), 128'd60);
          end
        end
        checks++;
        fifo_empty = 1'b1;
        @(negedge clk);
        fifo_empty = 1'b0;
        since_empty = 0;
      end
    end
  end

  task automatic push_byte(logic [7:0] b, bit last, bit first, int ch, int plen, bit scramble);
    bit hs;
    in_valid = 1'b1;
    in_data  = b;
    in_last  = last;
    if (first || !scramble) begin
      in_chan = 4'(ch);
      in_len  = 14'(plen);
    end else begin
      in_chan = 4'($urandom_range(0, 15));
      in_len  = 14'($urandom_range(0, 16383));
    end
    hs = 1'b0;
    while (!hs) begin
      hs = in_ready;
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic run_frame(int ch, int plen, bit scramble, string tag);
    int nb, nw, tries;
    bit valid_ch, seen_last;
    got_w.delete();
    got_l.delete();
    err_seen = 0;
    valid_ch = (ch >= 1 && ch <= 12);
    for (int k = 0; k < plen; k++) push_byte(pay[k], k == plen - 1, k == 0, ch, plen, scramble);
    in_valid = 1'b0;
    in_last  = 1'b0;
    if (valid_ch) begin
      seen_last = 0;
      tries = 0;
      while (!seen_last && tries < 3000) begin
        @(negedge clk);
        tries++;
        foreach (got_l[j]) if (got_l[j]) seen_last = 1;
      end
      repeat (3) @(negedge clk);
      // expected byte stream after the routing word
      nb = 8 + plen;
      for (int k = 0; k < 8; k++) stream[k] = 8'((64'(plen) + 64'd8) >> (8 * k));
      for (int k = 0; k < plen; k++) stream[8 + k] = pay[k];
      if (nb % 16 == 0) nw = nb / 16 + 1;
      else              nw = (nb + 15) / 16;
      for (int k = nb; k < nw * 16; k++) stream[k] = 8'h00;
      check(got_w.size() == nw + 1, "R10", {tag, " word count"}, 128'(got_w.size()), 128'(nw + 1));
      if (got_w.size() == nw + 1) begin
        check(got_w[0] == exp_route(ch) && !got_l[0], "R2", {tag, " routing word"}, got_w[0], exp_route(ch));
        for (int w = 0; w < nw; w++) begin
          logic [127:0] e;
          for (int b = 0; b < 16; b++) e[b*8 +: 8] = stream[w*16 + b];
          if (w == 0)
            check(got_w[1][63:0] == e[63:0], "R4", {tag, " length field"}, got_w[1], e);
          if (w == nw - 1) begin
            if (nb % 16 == 0)
              check(got_w[w+1] == '0, "R7", {tag, " zero close word"}, got_w[w+1], e);
            else
              check(got_w[w+1] == e, "R6", {tag, " padded close word"}, got_w[w+1], e);
            check(got_l[w+1] == 1'b1, "R10", {tag, " last flag on final"}, 128'(got_l[w+1]), 128'd1);
          end else begin
            check(got_w[w+1] == e, scramble ? "R9" : "R5", {tag, " body word"}, got_w[w+1], e);
            check(got_l[w+1] == 1'b0, "R10", {tag, " no early last"}, 128'(got_l[w+1]), 128'd0);
          end
        end
      end
    end else begin
      repeat (6) @(negedge clk);
      check(err_seen == 1, "R3", {tag, " error pulse"}, 128'(err_seen), 128'd1);
      check(got_w.size() == 0, "R3", {tag, " no words for rejected"}, 128'(got_w.size()), 128'd0);
    end
  endtask

  // Watchdog
  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!out_valid && !out_last && !err, "R1", "outputs after reset", {out_valid, out_last, err}, '0);
    check(!in_ready, "R1", "in_ready after reset", 128'(in_ready), 128'd0);

    for (int k = 0; k < 256; k++) pay[k] = 8'(k * 7 + 3);
    run_frame(1, 1, 0, "R6 one byte");
    run_frame(12, 8, 0, "R7 boundary 8");
    run_frame(5, 24, 0, "R7 boundary 24");
    run_frame(3, 7, 0, "R6 seven");
    run_frame(7, 40, 1, "R9 scrambled");
    run_frame(0, 5, 0, "R3 chan 0");
    run_frame(13, 3, 0, "R3 chan 13");
    run_frame(15, 1, 0, "R3 chan 15");
    run_frame(2, 17, 0, "R5 seventeen");

    for (int f = 0; f < 40; f++) begin
      int ch, pl;
      ch = $urandom_range(0, 15);
      pl = $urandom_range(1, 120);
      for (int k = 0; k < pl; k++) pay[k] = 8'($urandom_range(0, 255));
      run_frame(ch, pl, f[0], "R5 random");
    end
    run_frame(11, 56, 0, "R7 boundary 56");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule